// File: doc/BRIEF.md
# Display List Character Playfield Fetcher

This block is the video DMA sequencer of a character-mode playfield. It walks a list of instruction bytes stored in memory. Each instruction either produces empty scanlines, produces a band of text, reloads the screen data pointer, or redirects the list. For every text scanline it reads the screen codes of the character row and the glyph byte that each code selects for the current pixel row. It delivers the resulting pattern bytes as a stream with a valid flag. Blank scanlines are marked with a one-cycle flag instead.

A scanline strobe advances the block by one scanline. A frame-start strobe reloads the list pointer from a CPU-written register, and the block then waits for the next scanline strobe. The CPU sets four byte-wide registers through a small write port: a control byte, the list pointer low and high bytes, and the page of the glyph table. Memory is read through a synchronous port. Read data returns on the cycle after the request.

Top module: `dlist_text_fetch`

## Requirements
- R1: After reset, `pix_valid`, `blank_line` and `mem_req` are all low.
- R2: An instruction whose low nibble is 0 is a blank band of (bits 6:4 + 1) scanlines, so 0x70 gives 8 and 0x30 gives 4. Each of those scanline strobes gives exactly one `blank_line` pulse and no pattern bytes.
- R3: An instruction whose low nibble is 2 is a text band. Each of its scanlines emits 40 pattern bytes in column order. Byte c is read at char_page*256 + (code & 0x7F)*8 + row, where code is the byte at screen pointer + c.
- R4: A text band lasts 8 scanlines, with row running 0 to 7. All 8 scanlines reuse the same 40 codes. After the eighth scanline the screen pointer advances by 40.
- R5: If bit 6 is set on a text instruction, the next two list bytes are loaded into the screen pointer (low byte first) before the first scanline of that band.
- R6: Instruction 0x41 loads the next two list bytes (low byte first) into the list pointer. It then stops list processing: later scanline strobes issue no memory read and give no output until a frame start.
- R7: A frame start loads the list pointer from the register pair (select 1 = low byte, select 2 = high byte), and the next scanline strobe fetches the first instruction there. A scanline strobe in the same cycle as a frame start is dropped.
- R8: Control register (select 0) bit 5 enables list DMA. While it is clear, scanline strobes cause no memory reads and no output.
- R9: Register select 3 holds the page (high address byte) of the glyph table.
- R10: An instruction with low nibble 1 and bit 6 clear loads the list pointer from the next two bytes. It then fetches the next instruction within the same scanline.
- R11: An instruction with low nibble 3 to 15 produces a single blank scanline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 list low, 2 list high, 3 glyph page |
| reg_wdata | input | 8 | Register write data |
| frame_start | input | 1 | Vertical blank strobe, one cycle |
| line_strobe | input | 1 | Scanline start strobe, one cycle |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 8 | Read data, valid the cycle after the request |
| pix_byte | output | 8 | Glyph pattern byte |
| pix_valid | output | 1 | Qualifies `pix_byte` |
| blank_line | output | 1 | One-cycle pulse for a blank scanline |

## Verification
A frame start and a scanline strobe can arrive in the same cycle. In that case the pointer reload must win and the strobe must be lost. The bench drives both on one edge and then observes a full line period in which no read and no output may appear. The next strobe must then give the first instruction of the list, which is a blank band. A second collision pairs a frame start with DMA disabled. The pointer must still reload, so that re-enabling DMA resumes at the list start.

// File: rtl/dlf_pkg.sv
package dlf_pkg;

    typedef enum logic [3:0] {
        S_WAIT,
        S_INSTR_REQ,
        S_INSTR_DEC,
        S_ADDR_LO,
        S_ADDR_HI,
        S_TXT_CODE,
        S_TXT_GLYPH,
        S_HOLD
    } seq_state_e;

    typedef enum logic [1:0] {
        K_BLANK,
        K_TEXT,
        K_JUMP
    } instr_kind_e;

    typedef struct packed {
        instr_kind_e kind;
        logic        wait_vb;
        logic        load_addr;
        logic [2:0]  last_row;
    } instr_dec_t;

endpackage

// File: rtl/dlf_regs.sv
module dlf_regs #(
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 16,
    parameter int DMA_BIT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic              dma_en,
    output logic [ADDR_W-1:0] list_base,
    output logic [DATA_W-1:0] char_page
);
    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_LO   = 2'd1;
    localparam logic [1:0] SEL_HI   = 2'd2;
    localparam logic [1:0] SEL_PAGE = 2'd3;

    typedef struct packed {
        logic              dma;
        logic [ADDR_W-1:0] base;
        logic [DATA_W-1:0] page;
    } regs_t;

    regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (reg_we) begin
            unique case (reg_sel)
                SEL_CTRL: r_d.dma = reg_wdata[DMA_BIT];
                SEL_LO:   r_d.base[DATA_W-1:0] = reg_wdata;
                SEL_HI:   r_d.base[ADDR_W-1:DATA_W] = reg_wdata[ADDR_W-DATA_W-1:0];
                SEL_PAGE: r_d.page = reg_wdata;
                default:  r_d = r_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign dma_en    = r_q.dma;
    assign list_base = r_q.base;
    assign char_page = r_q.page;

    // R7: a low pointer byte write lands in the pointer on the next cycle
    p_lo_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel == SEL_LO) |=> (list_base[DATA_W-1:0] == $past(reg_wdata)));

    // R8: the enable follows bit 5 of a control write
    p_ctrl_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel == SEL_CTRL) |=> (dma_en == $past(reg_wdata[DMA_BIT])));

endmodule

// File: rtl/dlf_decode.sv
module dlf_decode
    import dlf_pkg::*;
#(
    parameter int TEXT_ROWS = 8
) (
    input  logic [6:0] op,
    output instr_dec_t dec
);
    localparam logic [2:0] TEXT_LAST = 3'(TEXT_ROWS - 1);

    always_comb begin
        dec           = '0;
        dec.kind      = K_BLANK;
        unique case (op[3:0])
            4'h0: dec.last_row = op[6:4];
            4'h1: begin
                dec.kind      = K_JUMP;
                dec.wait_vb   = op[6];
                dec.load_addr = 1'b1;
            end
            4'h2: begin
                dec.kind      = K_TEXT;
                dec.load_addr = op[6];
                dec.last_row  = TEXT_LAST;
            end
            default: dec.last_row = 3'd0;
        endcase
    end

    // R10: every jump form carries an address
    always_comb begin
        if (op[3:0] == 4'h1) a_jump_addr_r10: assert (dec.load_addr);
    end

endmodule

// File: rtl/dlf_seq.sv
module dlf_seq
    import dlf_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int COLS   = 40,
    parameter int CODE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start_i,
    input  logic              line_strobe_i,
    input  logic              dma_en_i,
    input  logic [ADDR_W-1:0] list_base_i,
    input  logic [DATA_W-1:0] char_page_i,
    input  instr_dec_t        dec_i,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic [DATA_W-1:0] pix_byte_o,
    output logic              pix_valid_o,
    output logic              blank_line_o
);
    localparam int COL_W = $clog2(COLS);
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);

    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] dl_ptr;
        logic [ADDR_W-1:0] scr_ptr;
        logic [DATA_W-1:0] addr_lo;
        instr_dec_t        cur;
        logic              active;
        logic [2:0]        row;
        logic [COL_W-1:0]  col;
        logic              glyph_pend;
        logic [DATA_W-1:0] pix;
        logic              pix_vld;
        logic              blank;
    } seq_t;

    seq_t q, n;
    logic line_go;
    logic [ADDR_W-1:0] jump_addr;
    logic [ADDR_W-1:0] glyph_addr;

    assign line_go    = line_strobe_i && dma_en_i && !frame_start_i;
    assign jump_addr  = {mem_rdata_i[ADDR_W-DATA_W-1:0], q.addr_lo};
    assign glyph_addr = {char_page_i, {(ADDR_W-DATA_W){1'b0}}}
                      + ADDR_W'({mem_rdata_i[CODE_W-1:0], 3'b000})
                      + ADDR_W'(q.row);

    always_comb begin
        n            = q;
        n.glyph_pend = 1'b0;
        n.pix_vld    = q.glyph_pend;
        n.blank      = 1'b0;
        if (q.glyph_pend) n.pix = mem_rdata_i;
        mem_req_o    = 1'b0;
        mem_addr_o   = '0;

        unique case (q.st)
            S_WAIT: begin
                if (line_go) begin
                    if (!q.active) begin
                        n.st = S_INSTR_REQ;
                    end else if (q.cur.kind == K_TEXT) begin
                        n.col = '0;
                        n.st  = S_TXT_CODE;
                    end else begin
                        n.blank = 1'b1;
                        if (q.row == q.cur.last_row) n.active = 1'b0;
                        else                         n.row    = q.row + 3'd1;
                    end
                end
            end
            S_INSTR_REQ: begin
                mem_req_o  = 1'b1;
                mem_addr_o = q.dl_ptr;
                n.dl_ptr   = q.dl_ptr + 1'b1;
                n.st       = S_INSTR_DEC;
            end
            S_INSTR_DEC: begin
                n.cur    = dec_i;
                n.active = 1'b1;
                n.row    = 3'd0;
                if (dec_i.load_addr) begin
                    mem_req_o  = 1'b1;
                    mem_addr_o = q.dl_ptr;
                    n.dl_ptr   = q.dl_ptr + 1'b1;
                    n.st       = S_ADDR_LO;
                end else if (dec_i.kind == K_TEXT) begin
                    n.col = '0;
                    n.st  = S_TXT_CODE;
                end else begin
                    n.blank = 1'b1;
                    n.st    = S_WAIT;
                    if (dec_i.last_row == 3'd0) n.active = 1'b0;
                    else                        n.row    = 3'd1;
                end
            end
            S_ADDR_LO: begin
                n.addr_lo  = mem_rdata_i;
                mem_req_o  = 1'b1;
                mem_addr_o = q.dl_ptr;
                n.dl_ptr   = q.dl_ptr + 1'b1;
                n.st       = S_ADDR_HI;
            end
            S_ADDR_HI: begin
                if (q.cur.kind == K_JUMP) begin
                    n.dl_ptr = jump_addr;
                    n.active = 1'b0;
                    n.st     = q.cur.wait_vb ? S_HOLD : S_INSTR_REQ;
                end else begin
                    n.scr_ptr = jump_addr;
                    n.col     = '0;
                    n.st      = S_TXT_CODE;
                end
            end
            S_TXT_CODE: begin
                mem_req_o  = 1'b1;
                mem_addr_o = q.scr_ptr + ADDR_W'(q.col);
                n.st       = S_TXT_GLYPH;
            end
            S_TXT_GLYPH: begin
                mem_req_o    = 1'b1;
                mem_addr_o   = glyph_addr;
                n.glyph_pend = 1'b1;
                if (q.col == COL_LAST) begin
                    n.st = S_WAIT;
                    if (q.row == q.cur.last_row) begin
                        n.active  = 1'b0;
                        n.scr_ptr = q.scr_ptr + ADDR_W'(COLS);
                    end else begin
                        n.row = q.row + 3'd1;
                    end
                end else begin
                    n.col = q.col + 1'b1;
                    n.st  = S_TXT_CODE;
                end
            end
            S_HOLD: n.st = S_HOLD;
            default: n.st = S_WAIT;
        endcase

        if (!dma_en_i) n.st = S_WAIT;

        if (frame_start_i) begin
            n.st     = S_WAIT;
            n.dl_ptr = list_base_i;
            n.active = 1'b0;
            n.row    = 3'd0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign pix_byte_o   = q.pix;
    assign pix_valid_o  = q.pix_vld;
    assign blank_line_o = q.blank;

    // R8: with DMA off no read is issued on the following cycle
    p_dma_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en_i |=> !mem_req_o);

    // R6: a scanline strobe during the hold causes no read
    p_hold_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_HOLD && line_strobe_i && !frame_start_i) |=> !mem_req_o);

    // R3: each pattern byte comes from a read two cycles earlier
    p_pix_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid_o |-> $past(mem_req_o, 2));

    // R2: a blank pulse never overlaps a pattern byte
    p_blank_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(pix_valid_o && blank_line_o));

    // R7: after a frame start the block sits idle for a cycle
    p_frame_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_i |=> !mem_req_o);

endmodule

// File: rtl/dlist_text_fetch.sv
module dlist_text_fetch
    import dlf_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int COLS      = 40,
    parameter int TEXT_ROWS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              frame_start,
    input  logic              line_strobe,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] pix_byte,
    output logic              pix_valid,
    output logic              blank_line
);
    logic              dma_en;
    logic [ADDR_W-1:0] list_base;
    logic [DATA_W-1:0] char_page;
    instr_dec_t        dec;

    dlf_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .dma_en    (dma_en),
        .list_base (list_base),
        .char_page (char_page)
    );

    dlf_decode #(
        .TEXT_ROWS (TEXT_ROWS)
    ) u_dec (
        .op  (mem_rdata[6:0]),
        .dec (dec)
    );

    dlf_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .COLS   (COLS)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_start_i (frame_start),
        .line_strobe_i (line_strobe),
        .dma_en_i      (dma_en),
        .list_base_i   (list_base),
        .char_page_i   (char_page),
        .dec_i         (dec),
        .mem_req_o     (mem_req),
        .mem_addr_o    (mem_addr),
        .mem_rdata_i   (mem_rdata),
        .pix_byte_o    (pix_byte),
        .pix_valid_o   (pix_valid),
        .blank_line_o  (blank_line)
    );

endmodule

// File: tb/sim_dlist_text_fetch.sv
`timescale 1ns/1ps
module sim_dlist_text_fetch;
    localparam int LINE_GAP = 126;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [7:0]  reg_wdata = '0;
    logic        frame_start = 1'b0;
    logic        line_strobe = 1'b0;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata = '0;
    logic [7:0]  pix_byte;
    logic        pix_valid;
    logic        blank_line;

    logic [7:0] mem [0:4095];
    logic [7:0] cap [0:63];
    int cap_n = 0, blank_n = 0, req_n = 0;
    int total = 0, bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dlist_text_fetch u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .frame_start(frame_start), .line_strobe(line_strobe),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .pix_byte(pix_byte), .pix_valid(pix_valid), .blank_line(blank_line)
    );

    always @(posedge clk) if (mem_req) mem_rdata <= mem[mem_addr[11:0]];

    always @(posedge clk) begin
        #1;
        if (pix_valid) begin
            if (cap_n < 64) cap[cap_n] = pix_byte;
            cap_n++;
        end
        if (blank_line) blank_n++;
        if (mem_req) req_n++;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk); reg_we = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic set_ptr(input logic [15:0] a);
        wr(2'd1, a[7:0]);
        wr(2'd2, a[15:8]);
    endtask

    task automatic clear_counts();
        cap_n = 0; blank_n = 0; req_n = 0;
    endtask

    task automatic pulse_frame();
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
        tick(4);
    endtask

    task automatic do_line();
        @(negedge clk); clear_counts(); line_strobe = 1'b1;
        @(negedge clk); line_strobe = 1'b0;
        tick(LINE_GAP);
    endtask

    function automatic logic [7:0] glyph_exp(input logic [7:0] page,
            input logic [15:0] scr, input int c, input int row);
        logic [7:0] code;
        int a;
        code = mem[(int'(scr) + c) & 12'hFFF];
        a = (int'(page) * 256 + int'(code & 8'h7F) * 8 + row) & 12'hFFF;
        return mem[a];
    endfunction

    task automatic text_check(input logic [7:0] page, input logic [15:0] scr,
                              input int row, input string req);
        int bad_i;
        bad_i = -1;
        if (cap_n != 40) begin
            check(0, req, "pattern byte count", cap_n, 40);
        end else begin
            for (int c = 0; c < 40; c++)
                if (bad_i < 0 && cap[c] != glyph_exp(page, scr, c, row)) bad_i = c;
            if (bad_i < 0) check(1, req, "pattern bytes", 0, 0);
            else check(0, req, $sformatf("byte at column %0d row %0d", bad_i, row),
                       cap[bad_i], glyph_exp(page, scr, bad_i, row));
        end
        check(blank_n == 0, req, "no blank pulse on text line", blank_n, 0);
    endtask

    task automatic t_reset();
        check(!pix_valid, "R1", "pix_valid after reset", pix_valid, 0);
        check(!blank_line, "R1", "blank_line after reset", blank_line, 0);
        check(!mem_req, "R1", "mem_req after reset", mem_req, 0);
    endtask

    task automatic t_reference_frame();
        int p;
        p = 'h100;
        for (int i = 0; i < 3; i++) mem[p + i] = 8'h70;
        mem[p + 3] = 8'h42; mem[p + 4] = 8'h00; mem[p + 5] = 8'h04;
        for (int i = 0; i < 23; i++) mem[p + 6 + i] = 8'h02;
        mem[p + 29] = 8'h41; mem[p + 30] = 8'h00; mem[p + 31] = 8'h01;
        wr(2'd3, 8'h08);
        set_ptr(16'h0100);
        wr(2'd0, 8'h22);
        pulse_frame();
        for (int k = 0; k < 24; k++) begin
            do_line();
            check(blank_n == 1, "R2", $sformatf("blank pulses line %0d", k), blank_n, 1);
            check(cap_n == 0, "R2", $sformatf("pattern bytes line %0d", k), cap_n, 0);
        end
        for (int k = 0; k < 192; k++) begin
            do_line();
            text_check(8'h08, 16'(16'h0400 + (k / 8) * 40), k % 8,
                       (k < 8) ? "R5" : ((k % 8 == 0) ? "R4" : "R3"));
        end
        do_line();
        check(cap_n == 0 && blank_n == 0, "R6", "output on jump-and-wait line",
              cap_n + blank_n, 0);
        clear_counts();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); line_strobe = 1'b1;
            @(negedge clk); line_strobe = 1'b0;
            tick(LINE_GAP);
        end
        check(req_n == 0 && cap_n == 0 && blank_n == 0, "R6",
              "activity while holding", req_n + cap_n + blank_n, 0);
        pulse_frame();
        do_line();
        check(blank_n == 1 && cap_n == 0, "R7", "first line after frame start", blank_n, 1);
    endtask

    task automatic t_coincident();
        pulse_frame();
        do_line();
        @(negedge clk); clear_counts(); frame_start = 1'b1; line_strobe = 1'b1;
        @(negedge clk); frame_start = 1'b0; line_strobe = 1'b0;
        tick(LINE_GAP);
        check(req_n == 0 && cap_n == 0 && blank_n == 0, "R7",
              "strobe coinciding with frame start", req_n + cap_n + blank_n, 0);
        do_line();
        check(blank_n == 1 && req_n == 1, "R7", "reads on first line after collision", req_n, 1);
    endtask

    task automatic t_dma_off();
        wr(2'd0, 8'h02);
        pulse_frame();
        do_line();
        check(req_n == 0 && cap_n == 0 && blank_n == 0, "R8", "activity with DMA off",
              req_n + cap_n + blank_n, 0);
        wr(2'd0, 8'h22);
        do_line();
        check(blank_n == 1 && req_n == 1, "R8", "resume at list start after enable", blank_n, 1);
    endtask

    task automatic t_page_and_lms();
        mem['h200] = 8'h42; mem['h201] = 8'h40; mem['h202] = 8'h06;
        wr(2'd3, 8'h0C);
        set_ptr(16'h0200);
        pulse_frame();
        do_line();
        text_check(8'h0C, 16'h0640, 0, "R9");
        do_line();
        text_check(8'h0C, 16'h0640, 1, "R9");
        wr(2'd3, 8'h08);
    endtask

    task automatic t_jump_and_odd();
        mem['h300] = 8'h01; mem['h301] = 8'h10; mem['h302] = 8'h03;
        mem['h310] = 8'h0F; mem['h311] = 8'h30;
        mem['h312] = 8'h41; mem['h313] = 8'h10; mem['h314] = 8'h03;
        set_ptr(16'h0300);
        pulse_frame();
        do_line();
        check(req_n == 4, "R10", "reads for jump plus next instruction", req_n, 4);
        check(blank_n == 1 && cap_n == 0, "R11", "odd mode gives one blank line", blank_n, 1);
        for (int i = 0; i < 4; i++) begin
            do_line();
            check(blank_n == 1 && cap_n == 0, "R2", $sformatf("0x30 band line %0d", i), blank_n, 1);
        end
        do_line();
        check(blank_n == 0 && cap_n == 0, "R2", "0x30 band ends after 4 lines", blank_n, 0);
    endtask

    initial begin
        for (int a = 0; a < 4096; a++) mem[a] = 8'((a * 37) ^ (a >> 5));
        tick(5);
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_reference_frame();
        t_coincident();
        t_dma_off();
        t_page_and_lms();
        t_jump_and_odd();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule